// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Front End

This block is the bus-facing half of a 256-byte serial memory. It oversamples the two-wire bus clock and data lines on a fast system clock and recognises bus start, repeated start and stop conditions. It takes in a device-select byte and answers it only when three conditions hold. The upper four bits must equal one of two build-time family identifiers, chosen by a pin. The next three bits must equal the strap inputs. The external write engine must not be busy.

After a write select, the block loads the following byte into its word pointer. Each later byte is passed to the storage side as a one-cycle write handoff carrying the pointer address, and the pointer then advances. After a read select, it serves bytes from a combinational memory read port, starting at the current pointer. The pointer advances after every byte and wraps from 255 to 0. The read goes on for as long as the master acknowledges.

The data line is driven through an open-drain enable: a 1 pulls the line low. The storage array, the write timer, input glitch filtering and bus timing checks are not part of this block.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the data-line pull-down is off, no write handoff is pulsed and the word pointer (seen on memRdAddr) is 0.
- R2: A falling data line while the clock line is high (START) begins a new select byte from any state. A rising data line while the clock is high (STOP) returns the block to idle with the data line released.
- R3: A select byte sent MSB first is acknowledged, by pulling the data line low through the ninth clock, only when bits 7..4 equal the family code (1010 when typeSel is 0, 0010 when typeSel is 1) and bits 3..1 equal strap[2:0]. Bit 0 = 1 selects a read.
- R4: After an acknowledged write select, the next byte is acknowledged and becomes the word pointer.
- R5: Each later write byte is acknowledged and handed off as one memWrValid pulse with memWrAddr equal to the pointer and memWrData equal to the byte. The pointer then increments.
- R6: Read bytes are memRdData at the pointer, sent MSB first. The pointer increments after each byte and wraps from 255 to 0.
- R7: A read select without a preceding word address starts at the current pointer. A write select, a word address, a repeated START and a read select start at that word address.
- R8: A master acknowledge (data low on the ninth clock) continues the read. A master NACK ends it, and the block drives nothing until the next START.
- R9: While wrBusy is high, the block does not acknowledge a select byte that otherwise matches.
- R10: After a select byte that does not match, the block ignores all clocks until the next START.
- R11: A START or STOP in the middle of a byte discards that byte and restarts bit counting. A write byte cut short this way is never handed off.
- R12: The data-line enable changes only after a clock falling edge, never while the synchronized clock line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| typeSel | input | 1 | Family code select: 0 gives 1010, 1 gives 0010 |
| strap | input | 3 | Device address straps compared with select bits 3..1 |
| wrBusy | input | 1 | Write engine busy; select bytes are not acknowledged |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | Data-line pull-down enable (1 drives low) |
| memRdAddr | output | ADDR_W | Word pointer, used as the read address |
| memRdData | input | 8 | Read data for memRdAddr, same cycle |
| memWrValid | output | 1 | One-cycle write handoff strobe |
| memWrAddr | output | ADDR_W | Write handoff address |
| memWrData | output | 8 | Write handoff data |

## Verification
The bench targets the cases where the bit counter and the pointer can drift. A STOP or START halfway through a byte must neither commit a write nor leave the counter offset; a design that kept counting would miss the next select or acknowledge on the wrong clock. A read from 0xFE must return 0xFE, 0xFF and then 0x00; a design that carried the pointer into extra bits or saturated it would return wrong data on the third byte. A select that misses is followed by a correct select sent without a START. A design that kept listening would acknowledge that second byte. A design that ignored the busy input would acknowledge while a write is in progress. After a master NACK, an extra clock is issued to catch a design that keeps shifting data out.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  localparam int BYTE_W  = 8;
  localparam int TYPE_W  = 4;
  localparam int STRAP_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEVACK,
    ST_ADDR,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic rxBit;
    logic txCount;
    logic txLoad;
    logic txShift;
    logic loadPtr;
    logic incPtr;
    logic wrStrobe;
    logic driveAck;
    logic relSda;
  } dpCtrl_t;

  // bus events seen after synchronization
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic sdaLvl;
  } busEv_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
  import i2c_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  output busEv_t ev,
  output logic   sclSync
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    ev.startEv = sclNow && sclPrev && sdaPrev && !sdaNow;
    ev.stopEv  = sclNow && sclPrev && !sdaPrev && sdaNow;
    ev.sclRise = sclNow && !sclPrev;
    ev.sclFall = !sclNow && sclPrev;
    ev.sdaLvl  = sdaNow;
  end

  assign sclSync = sclNow;

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  busEv_t             ev,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic               byteFull,
  input  logic [TYPE_W-1:0]  devType,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wrBusy,
  output dpCtrl_t            ctl,
  output ctrlState_t         state
);

  ctrlState_t nxtState;
  logic       readMode;
  logic       nxtRead;
  logic       selHit;

  assign selHit = (rxByte[BYTE_W-1 -: TYPE_W] == devType) &&
                  (rxByte[STRAP_W:1] == strap) && !wrBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      readMode <= 1'b0;
    end else begin
      state    <= nxtState;
      readMode <= nxtRead;
    end
  end

  always_comb begin
    ctl      = '0;
    nxtState = state;
    nxtRead  = readMode;
    if (ev.startEv) begin
      ctl.clrBits = 1'b1;
      ctl.relSda  = 1'b1;
      nxtState    = ST_DEV;
    end else if (ev.stopEv) begin
      ctl.clrBits = 1'b1;
      ctl.relSda  = 1'b1;
      nxtState    = ST_IDLE;
    end else begin
      unique case (state)
        ST_DEV: begin
          if (ev.sclRise) begin
            ctl.rxBit = 1'b1;
          end else if (ev.sclFall && byteFull) begin
            if (selHit) begin
              ctl.driveAck = 1'b1;
              nxtRead      = rxByte[0];
              nxtState     = ST_DEVACK;
            end else begin
              nxtState = ST_IDLE;
            end
          end
        end
        ST_DEVACK: begin
          if (ev.sclFall) begin
            if (readMode) begin
              ctl.txLoad = 1'b1;
              nxtState   = ST_RDATA;
            end else begin
              ctl.relSda  = 1'b1;
              ctl.clrBits = 1'b1;
              nxtState    = ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (ev.sclRise) begin
            ctl.rxBit = 1'b1;
          end else if (ev.sclFall && byteFull) begin
            ctl.loadPtr  = 1'b1;
            ctl.driveAck = 1'b1;
            nxtState     = ST_WACK;
          end
        end
        ST_WDATA: begin
          if (ev.sclRise) begin
            ctl.rxBit = 1'b1;
          end else if (ev.sclFall && byteFull) begin
            ctl.wrStrobe = 1'b1;
            ctl.incPtr   = 1'b1;
            ctl.driveAck = 1'b1;
            nxtState     = ST_WACK;
          end
        end
        ST_WACK: begin
          if (ev.sclFall) begin
            ctl.relSda  = 1'b1;
            ctl.clrBits = 1'b1;
            nxtState    = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (ev.sclRise) begin
            ctl.txCount = 1'b1;
          end else if (ev.sclFall) begin
            if (byteFull) begin
              ctl.relSda = 1'b1;
              ctl.incPtr = 1'b1;
              nxtState   = ST_RACK;
            end else begin
              ctl.txShift = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (ev.sclRise && ev.sdaLvl) begin
            nxtState = ST_IDLE;
          end else if (ev.sclFall) begin
            ctl.txLoad = 1'b1;
            nxtState   = ST_RDATA;
          end
        end
        default: nxtState = state;
      endcase
    end
  end

endmodule

// File: rtl/i2c_mem_dp.sv
module i2c_mem_dp
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              sdaLvl,
  input  logic [BYTE_W-1:0] memRdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteFull,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaOe,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [BYTE_W-1:0] memWrData
);

  localparam int BIT_CW = $clog2(BYTE_W + 1);

  logic [BIT_CW-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] txReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (ctl.clrBits || ctl.txLoad) begin
      bitCnt <= '0;
    end else if (ctl.rxBit) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaLvl};
      bitCnt   <= bitCnt + BIT_CW'(1);
    end else if (ctl.txCount) begin
      bitCnt <= bitCnt + BIT_CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg <= '1;
      sdaOe <= 1'b0;
    end else if (ctl.relSda) begin
      sdaOe <= 1'b0;
    end else if (ctl.driveAck) begin
      sdaOe <= 1'b1;
    end else if (ctl.txLoad) begin
      sdaOe <= !memRdData[BYTE_W-1];
      txReg <= {memRdData[BYTE_W-2:0], 1'b1};
    end else if (ctl.txShift) begin
      sdaOe <= !txReg[BYTE_W-1];
      txReg <= {txReg[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctl.loadPtr) begin
      ptr <= shiftReg[ADDR_W-1:0];
    end else if (ctl.incPtr) begin
      ptr <= ptr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrValid <= 1'b0;
      memWrAddr  <= '0;
      memWrData  <= '0;
    end else begin
      memWrValid <= ctl.wrStrobe;
      if (ctl.wrStrobe) begin
        memWrAddr <= ptr;
        memWrData <= shiftReg;
      end
    end
  end

  assign rxByte   = shiftReg;
  assign byteFull = (bitCnt == BIT_CW'(BYTE_W));

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter logic [TYPE_W-1:0] TYPE_ID_A   = 4'b1010,
  parameter logic [TYPE_W-1:0] TYPE_ID_B   = 4'b0010,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               typeSel,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wrBusy,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  output logic [ADDR_W-1:0]  memRdAddr,
  input  logic [BYTE_W-1:0]  memRdData,
  output logic               memWrValid,
  output logic [ADDR_W-1:0]  memWrAddr,
  output logic [BYTE_W-1:0]  memWrData
);

  busEv_t            ev;
  logic              sclSync;
  dpCtrl_t           ctl;
  ctrlState_t        ctrlState;
  logic [BYTE_W-1:0] rxByte;
  logic              byteFull;
  logic [TYPE_W-1:0] devType;
  logic              stopEv;

  assign devType = typeSel ? TYPE_ID_B : TYPE_ID_A;
  assign stopEv  = ev.stopEv;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .ev      (ev),
    .sclSync (sclSync)
  );

  i2c_mem_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ev       (ev),
    .rxByte   (rxByte),
    .byteFull (byteFull),
    .devType  (devType),
    .strap    (strap),
    .wrBusy   (wrBusy),
    .ctl      (ctl),
    .state    (ctrlState)
  );

  i2c_mem_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sdaLvl     (ev.sdaLvl),
    .memRdData  (memRdData),
    .rxByte     (rxByte),
    .byteFull   (byteFull),
    .ptr        (memRdAddr),
    .sdaOe      (sdaOe),
    .memWrValid (memWrValid),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_mem_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       sclSync,
  input logic       stopEv,
  input logic       memWrValid,
  input logic       wrBusy,
  input ctrlState_t ctrlState
);

  AST_SDA_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclSync))
    else $error("data enable moved while clock high"); // R12

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe)
    else $error("data line held after stop"); // R2

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_DEVACK && $rose(sdaOe)) |-> !$past(wrBusy))
    else $error("select acknowledged while busy"); // R9

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |=> !memWrValid)
    else $error("write handoff longer than one cycle"); // R5

  AST_WR_IN_WRITE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> ctrlState == ST_WACK)
    else $error("write handoff outside write data phase"); // R5

endmodule

bind i2c_mem_target i2c_mem_target_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sdaOe      (sdaOe),
  .sclSync    (sclSync),
  .stopEv     (stopEv),
  .memWrValid (memWrValid),
  .wrBusy     (wrBusy),
  .ctrlState  (ctrlState)
);

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;

  localparam int QTR    = 10;
  localparam int ADDR_W = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       typeSel = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       wrBusy = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaOe;
  logic       sdaBus;
  logic [ADDR_W-1:0] memRdAddr;
  logic [7:0] memRdData;
  logic       memWrValid;
  logic [ADDR_W-1:0] memWrAddr;
  logic [7:0] memWrData;

  logic [7:0] mem [256];
  int         wrCount;
  int         nChecks = 0;
  int         nFails  = 0;

  always #5 clk = ~clk;

  assign sdaBus    = sdaM & ~sdaOe;
  assign memRdData = mem[memRdAddr];

  i2c_mem_target i_i2c_mem_target (
    .clk        (clk),
    .rstN       (rstN),
    .typeSel    (typeSel),
    .strap      (strap),
    .wrBusy     (wrBusy),
    .sclIn      (sclM),
    .sdaIn      (sdaBus),
    .sdaOe      (sdaOe),
    .memRdAddr  (memRdAddr),
    .memRdData  (memRdData),
    .memWrValid (memWrValid),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );

  function automatic logic [7:0] initVal(input logic [7:0] a);
    return (a * 8'd7) ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= initVal(8'(i));
      wrCount <= 0;
    end else if (memWrValid) begin
      mem[memWrAddr] <= memWrData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic q();
    repeat (QTR) @(posedge clk);
    #2;
  endtask

  task automatic startCond();
    sdaM = 1'b1; q();
    sclM = 1'b1; q();
    sdaM = 1'b0; q();
    sclM = 1'b0; q();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; q();
    sclM = 1'b1; q();
    sdaM = 1'b1; q();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; q();
    sclM = 1'b1; q(); q();
    sclM = 1'b0; q();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; q();
    sclM = 1'b1; q();
    ack = ~sdaBus;
    q();
    sclM = 1'b0; q();
  endtask

  task automatic readByte(input logic masterAck, output logic [7:0] d, output logic stable);
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; q();
      sclM = 1'b1; q();
      d[i] = sdaBus;
      q();
      if (sdaBus !== d[i]) stable = 1'b0;
      sclM = 1'b0; q();
    end
    sdaM = masterAck ? 1'b0 : 1'b1; q();
    sclM = 1'b1; q(); q();
    sclM = 1'b0; q();
    sdaM = 1'b1;
  endtask

  task automatic selectOnly(input logic [7:0] sel, output logic ack);
    startCond();
    writeByte(sel, ack);
  endtask

  task automatic t_reset();
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 memWrValid", memWrValid, 0);
    chk("R1 pointer", memRdAddr, 0);
  endtask

  task automatic t_select();
    logic ack;
    selectOnly(8'hAA, ack); stopCond();
    chk("R3 match 1010/101", ack, 1);
    selectOnly(8'hA2, ack); stopCond();
    chk("R3 strap miss", ack, 0);
    selectOnly(8'h2A, ack); stopCond();
    chk("R3 family 0010 while typeSel=0", ack, 0);
    typeSel = 1'b1;
    selectOnly(8'h2A, ack); stopCond();
    chk("R3 family 0010 with typeSel=1", ack, 1);
    selectOnly(8'hAA, ack); stopCond();
    chk("R3 family 1010 with typeSel=1", ack, 0);
    typeSel = 1'b0;
  endtask

  task automatic t_ignoreAfterMiss();
    logic ack;
    selectOnly(8'hA2, ack);
    writeByte(8'hAA, ack);
    chk("R10 no ack without new START", ack, 0);
    stopCond();
  endtask

  task automatic t_write();
    logic ack;
    int base;
    base = wrCount;
    selectOnly(8'hAA, ack);
    writeByte(8'h40, ack);
    chk("R4 word address ack", ack, 1);
    writeByte(8'h11, ack); chk("R5 data ack 0", ack, 1);
    writeByte(8'h22, ack); chk("R5 data ack 1", ack, 1);
    writeByte(8'h33, ack); chk("R5 data ack 2", ack, 1);
    stopCond(); q();
    chk("R5 handoff count", wrCount - base, 3);
    chk("R5 mem 40", mem[8'h40], 8'h11);
    chk("R5 mem 42", mem[8'h42], 8'h33);
    chk("R5 pointer after write", memRdAddr, 8'h43);
  endtask

  task automatic t_randomRead();
    logic ack, st;
    logic [7:0] d;
    selectOnly(8'hAA, ack);
    writeByte(8'h40, ack);
    startCond();
    writeByte(8'hAB, ack);
    chk("R7 read select ack", ack, 1);
    readByte(1'b1, d, st); chk("R7 random read byte 0", d, 8'h11);
    chk("R12 data stable while clock high", st, 1);
    readByte(1'b1, d, st); chk("R6 random read byte 1", d, 8'h22);
    readByte(1'b0, d, st); chk("R6 random read byte 2", d, 8'h33);
    stopCond();
  endtask

  task automatic t_currentRead();
    logic ack, st;
    logic [7:0] d;
    selectOnly(8'hAB, ack);
    chk("R7 current read ack", ack, 1);
    readByte(1'b0, d, st);
    chk("R7 current address data", d, initVal(8'h43));
    stopCond(); q();
    chk("R6 pointer incremented", memRdAddr, 8'h44);
  endtask

  task automatic t_wrap();
    logic ack, st;
    logic [7:0] d;
    selectOnly(8'hAA, ack);
    writeByte(8'hFE, ack);
    startCond();
    writeByte(8'hAB, ack);
    readByte(1'b1, d, st); chk("R6 byte FE", d, initVal(8'hFE));
    readByte(1'b1, d, st); chk("R6 byte FF", d, initVal(8'hFF));
    readByte(1'b0, d, st); chk("R6 wrap to 00", d, initVal(8'h00));
    stopCond();
  endtask

  task automatic t_nack();
    logic ack, st;
    logic [7:0] d;
    selectOnly(8'hAA, ack);
    writeByte(8'h00, ack);
    startCond();
    writeByte(8'hAB, ack);
    readByte(1'b0, d, st);
    sdaM = 1'b1; q();
    sclM = 1'b1; q();
    chk("R8 no drive after NACK", sdaBus, 1);
    chk("R8 enable off after NACK", sdaOe, 0);
    q();
    sclM = 1'b0; q();
    stopCond();
  endtask

  task automatic t_busy();
    logic ack;
    wrBusy = 1'b1;
    selectOnly(8'hAA, ack); stopCond();
    chk("R9 no ack while busy", ack, 0);
    wrBusy = 1'b0;
    selectOnly(8'hAA, ack); stopCond();
    chk("R9 ack after busy clears", ack, 1);
  endtask

  task automatic t_midStop();
    logic ack;
    int base;
    base = wrCount;
    selectOnly(8'hAA, ack);
    writeByte(8'h50, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    stopCond(); q();
    chk("R11 no handoff on cut byte", wrCount - base, 0);
    chk("R11 mem 50 untouched", mem[8'h50], initVal(8'h50));
    selectOnly(8'hAA, ack); stopCond();
    chk("R2 select after STOP", ack, 1);
  endtask

  task automatic t_midStart();
    logic ack;
    startCond();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    startCond();
    writeByte(8'hAA, ack);
    chk("R11 counter reset by START", ack, 1);
    stopCond();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
    q();
    t_reset();
    t_select();
    t_ignoreAfterMiss();
    t_write();
    t_randomRead();
    t_currentRead();
    t_wrap();
    t_nack();
    t_busy();
    t_midStop();
    t_midStart();
    q();
    finishRun();
  end

endmodule